// File: doc/BRIEF.md
# Audio Frame Capture Sequencer

This block moves one complete frame of audio samples from a sample FIFO into the working memory of an FFT engine and then starts the transform. The microphone side keeps pushing samples into the FIFO on its own schedule, at a nominal rate of about 39 kHz. The sequencer does nothing until the FIFO reports that it holds a full frame of `2**ADDR_WIDTH` samples. It then pops the samples one at a time and writes each one to the next FFT memory address, starting at 0. After the last write it sends the engine a single-cycle start pulse.

The FIFO presents its head word without a read request, so it works as a first-word-fall-through FIFO. A read strobe pops that word. The sequencer registers every popped word, together with its address, onto the memory write port on the following cycle. Capture is tied to the transform. After a start pulse the sequencer waits for the engine's done pulse. It begins another frame only when the FIFO is full again and the engine does not report busy. Samples that arrive during the transform collect in the emptied FIFO and form the next frame.

Top module: `frame_capture_seq`

## Requirements
- R1: After a synchronous active-high reset, `fifo_rd_en`, `mem_we` and `fft_start` are 0 and `mem_addr` is 0.
- R2: A drain starts only when `fifo_full` is 1 and `fft_busy` is 0. While the FIFO holds fewer than a full frame, `fifo_rd_en` stays 0.
- R3: `fifo_rd_en` is asserted only while `fifo_empty` is 0. While the FIFO reports empty during a drain, the drain pauses and then resumes with the next address.
- R4: Each pop writes the popped word on the next cycle. `mem_we` is 1 and `mem_wdata` holds that word. `mem_addr` counts up from 0 by one per pop.
- R5: A frame consists of exactly `2**ADDR_WIDTH` writes, at addresses 0 through `2**ADDR_WIDTH-1`. Each frame starts again at address 0.
- R6: `fft_start` is high for exactly one cycle. It rises in the cycle after the write to the last address.
- R7: After a start pulse, no sample is read until `fft_done` has pulsed, even if the FIFO is full and the engine is not busy.
- R8: `fifo_full` is ignored while `fft_busy` is 1, including after `fft_done`. Draining begins once `fft_busy` falls.
- R9: A reset in the middle of a drain stops the reads and the writes. The next frame is written from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_rdata | input | DATA_WIDTH | Head word of the sample FIFO |
| fifo_full | input | 1 | FIFO holds a whole frame |
| fifo_empty | input | 1 | FIFO has no word |
| fft_busy | input | 1 | Transform in progress |
| fft_done | input | 1 | One-cycle transform completion pulse |
| fifo_rd_en | output | 1 | Pop the FIFO head word |
| mem_we | output | 1 | FFT memory write enable |
| mem_addr | output | ADDR_WIDTH | FFT memory write address |
| mem_wdata | output | DATA_WIDTH | FFT memory write data |
| fft_start | output | 1 | One-cycle transform start pulse |

## Verification
The bench holds the FIFO one sample short of full. A design that drains a partial frame would read there. The bench stalls the FIFO in the middle of a drain. A design that keeps counting during the stall would skip addresses or write stale data. It also checks the timing of the start pulse against the last-address write. A start that is one cycle early, or longer than one cycle, would let the engine read memory that is not yet complete.

The bench refills the FIFO while the engine is idle but has not yet sent its done pulse, and again while done has pulsed but busy is still high. A design that does not gate on either condition would overwrite memory that the engine is still using. Finally, a reset in the middle of a drain must bring the next frame back to address 0, not continue from where the counter stopped.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_START = 2'd2,
        ST_WAIT  = 2'd3
    } fcs_state_e;
endpackage

// File: rtl/fcs_addr_ctr.sv
module fcs_addr_ctr #(
    parameter int ADDR_WIDTH = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step,
    output logic [ADDR_WIDTH-1:0] count,
    output logic                  at_last
);
    localparam logic [ADDR_WIDTH-1:0] LAST_IDX = {ADDR_WIDTH{1'b1}};

    typedef struct packed {
        logic [ADDR_WIDTH-1:0] cnt;
    } ctr_t;

    ctr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (step) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign count   = r_q.cnt;
    assign at_last = (r_q.cnt == LAST_IDX);

    // R5: the frame index wraps back to zero after the last address
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (step && at_last) |=> (count == '0));
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_full,
    input  logic       fifo_empty,
    input  logic       fft_busy,
    input  logic       fft_done,
    input  logic       at_last,
    output logic       pop,
    output logic       start_pulse,
    output fcs_state_e state
);
    typedef struct packed {
        fcs_state_e st;
        logic       start;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  pop_c;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        pop_c     = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (fifo_full && !fft_busy) begin
                    r_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                pop_c = !fifo_empty;
                if (pop_c && at_last) begin
                    r_d.st = ST_START;
                end
            end
            ST_START: begin
                r_d.start = 1'b1;
                r_d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                if (fft_done) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, start: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pop         = pop_c;
    assign start_pulse = r_q.start;
    assign state       = r_q.st;

    // R2: an idle sequencer that is not cleared to go must stay out of the drain
    p_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && (!fifo_full || fft_busy)) |=> (state != ST_DRAIN));
    // R7: no reads from the moment of the start request until done returns to idle
    p_wait_no_read_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT || state == ST_START) |-> !pop);
endmodule

// File: rtl/fcs_wr_port.sv
module fcs_wr_port #(
    parameter int ADDR_WIDTH = 9,
    parameter int DATA_WIDTH = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  take,
    input  logic [ADDR_WIDTH-1:0] addr_in,
    input  logic [DATA_WIDTH-1:0] data_in,
    output logic                  we,
    output logic [ADDR_WIDTH-1:0] addr,
    output logic [DATA_WIDTH-1:0] data
);
    typedef struct packed {
        logic                  we;
        logic [ADDR_WIDTH-1:0] addr;
        logic [DATA_WIDTH-1:0] data;
    } wr_t;

    wr_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.we = take;
        if (take) begin
            r_d.addr = addr_in;
            r_d.data = data_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign we   = r_q.we;
    assign addr = r_q.addr;
    assign data = r_q.data;
endmodule

// File: rtl/frame_capture_seq.sv
module frame_capture_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_WIDTH = 9,
    parameter int DATA_WIDTH = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DATA_WIDTH-1:0] fifo_rdata,
    input  logic                  fifo_full,
    input  logic                  fifo_empty,
    input  logic                  fft_busy,
    input  logic                  fft_done,
    output logic                  fifo_rd_en,
    output logic                  mem_we,
    output logic [ADDR_WIDTH-1:0] mem_addr,
    output logic [DATA_WIDTH-1:0] mem_wdata,
    output logic                  fft_start
);
    localparam logic [ADDR_WIDTH-1:0] LAST_ADDR = {ADDR_WIDTH{1'b1}};

    logic                  pop;
    logic                  at_last;
    logic [ADDR_WIDTH-1:0] idx;
    fcs_state_e            state;

    fcs_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fft_busy   (fft_busy),
        .fft_done   (fft_done),
        .at_last    (at_last),
        .pop        (pop),
        .start_pulse(fft_start),
        .state      (state)
    );

    fcs_addr_ctr #(.ADDR_WIDTH(ADDR_WIDTH)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .step   (pop),
        .count  (idx),
        .at_last(at_last)
    );

    fcs_wr_port #(.ADDR_WIDTH(ADDR_WIDTH), .DATA_WIDTH(DATA_WIDTH)) u_wr (
        .clk    (clk),
        .rst    (rst),
        .take   (pop),
        .addr_in(idx),
        .data_in(fifo_rdata),
        .we     (mem_we),
        .addr   (mem_addr),
        .data   (mem_wdata)
    );

    assign fifo_rd_en = pop;

    // R3: never pop an empty FIFO
    p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |-> !fifo_empty);
    // R4: every pop lands on the write port one cycle later with the popped word
    p_pop_writes_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |=> (mem_we && mem_wdata == $past(fifo_rdata)));
    // R6: the start pulse lasts a single cycle
    p_start_one_r6: assert property (@(posedge clk) disable iff (rst)
        fft_start |=> !fft_start);
    // R6: the start pulse directly follows the write of the last address
    p_start_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fft_start) |-> ($past(mem_we) && $past(mem_addr) == LAST_ADDR));
endmodule

// File: tb/frame_capture_seq_tb.sv
`timescale 1ns/100ps
module frame_capture_seq_tb;
    localparam int AW    = 3;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        int unsigned addr;
        int unsigned data;
    } wr_item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fft_busy = 1'b0;
    logic          fft_done = 1'b0;
    logic          stall = 1'b0;
    logic [DW-1:0] fifo_rdata;
    logic          fifo_full, fifo_empty;
    logic          fifo_rd_en, mem_we, fft_start;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    logic [DW-1:0] fifo_q[$];
    wr_item_t      exp_q[$];
    int            total = 0;
    int            bad = 0;
    int            starts = 0;
    int            frame_writes = 0;
    int unsigned   exp_addr = 0;
    bit            pop_pending = 0;
    bit            no_read = 0;
    bit            prev_we_last = 0;
    bit            prev_start = 0;

    always #2.5 clk = ~clk;

    assign fifo_rdata = (fifo_q.size() > 0) ? fifo_q[0] : '0;
    assign fifo_empty = (fifo_q.size() == 0) || stall;
    assign fifo_full  = (fifo_q.size() >= DEPTH) && !stall;

    frame_capture_seq #(.ADDR_WIDTH(AW), .DATA_WIDTH(DW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .fifo_rdata(fifo_rdata),
        .fifo_full (fifo_full),
        .fifo_empty(fifo_empty),
        .fft_busy  (fft_busy),
        .fft_done  (fft_done),
        .fifo_rd_en(fifo_rd_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .fft_start (fft_start)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // FIFO model: pop slightly after the edge at which the design consumed the head
    always @(posedge clk) begin
        if (pop_pending) begin
            #0.5;
            if (fifo_q.size() > 0) void'(fifo_q.pop_front());
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            pop_pending = 0;
            prev_we_last = 0;
            prev_start = 0;
        end else begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R4", "unexpected write addr", int'(mem_addr), -1);
                end else begin
                    wr_item_t e;
                    e = exp_q.pop_front();
                    chk(int'(mem_addr) == e.addr, "R4", "write addr", int'(mem_addr), e.addr);
                    chk(int'(mem_wdata) == e.data, "R4", "write data", int'(mem_wdata), e.data);
                end
                frame_writes++;
            end
            if (prev_start) chk(!fft_start, "R6", "start width", fft_start, 0);
            if (fft_start && !prev_start) begin
                chk(prev_we_last, "R6", "start after last write", prev_we_last, 1);
                chk(frame_writes == DEPTH, "R5", "writes per frame", frame_writes, DEPTH);
                chk(exp_q.size() == 0, "R5", "pending writes at start", exp_q.size(), 0);
                starts++;
                frame_writes = 0;
            end
            if (no_read) chk(!fifo_rd_en, "R2/R7/R8/R3", "read while gated", fifo_rd_en, 0);
            if (fifo_rd_en) begin
                chk(!fifo_empty, "R3", "read on empty", fifo_empty, 0);
                exp_q.push_back('{addr: exp_addr, data: int'(fifo_rdata)});
                exp_addr = (exp_addr + 1) % DEPTH;
            end
            pop_pending  = fifo_rd_en;
            prev_we_last = mem_we && (int'(mem_addr) == DEPTH - 1);
            prev_start   = fft_start;
        end
    end

    task automatic push_samples(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            fifo_q.push_back(DW'(seed * 37 + i * 11 + 5));
        end
    endtask

    task automatic hold_no_read(input int n);
        no_read = 1;
        repeat (n) @(posedge clk);
        #1 no_read = 0;
    endtask

    task automatic wait_start();
        int s;
        s = starts;
        while (starts == s) @(negedge clk);
    endtask

    task automatic wait_writes(input int k);
        while (frame_writes < k) @(negedge clk);
    endtask

    task automatic pulse_done();
        @(posedge clk); #1 fft_done = 1;
        @(posedge clk); #1 fft_done = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(!fifo_rd_en, "R1", "rd_en after reset", fifo_rd_en, 0);
        chk(!mem_we, "R1", "mem_we after reset", mem_we, 0);
        chk(!fft_start, "R1", "start after reset", fft_start, 0);
        chk(mem_addr == 0, "R1", "addr after reset", int'(mem_addr), 0);

        // R2: one short of a frame, nothing is read
        push_samples(DEPTH - 1, 1);
        hold_no_read(6);
        push_samples(1, 99);
        wait_start();
        chk(starts == 1, "R5", "first frame started", starts, 1);

        // R7: full FIFO and idle engine, but no done yet
        push_samples(DEPTH, 2);
        hold_no_read(6);
        pulse_done();
        // R3: stall in the middle of the drain
        wait_writes(3);
        @(posedge clk); #1 stall = 1; no_read = 1;
        repeat (3) @(posedge clk);
        #1 stall = 0; no_read = 0;
        wait_start();
        chk(starts == 2, "R3", "stalled frame completed", starts, 2);

        // R8: done pulses while busy stays high
        @(posedge clk); #1 fft_busy = 1;
        push_samples(DEPTH, 3);
        no_read = 1;
        pulse_done();
        repeat (4) @(posedge clk);
        #1 fft_busy = 0; no_read = 0;
        wait_start();
        chk(starts == 3, "R8", "frame after busy released", starts, 3);

        // R9: reset in the middle of a drain
        pulse_done();
        push_samples(DEPTH, 4);
        wait_writes(3);
        @(posedge clk); #1 rst = 1;
        @(posedge clk); #1 rst = 0;
        fifo_q.delete();
        exp_q.delete();
        exp_addr = 0;
        frame_writes = 0;
        @(negedge clk);
        chk(!mem_we, "R9", "write after mid reset", mem_we, 0);
        chk(!fifo_rd_en, "R9", "read after mid reset", fifo_rd_en, 0);
        push_samples(DEPTH, 5);
        wait_start();
        chk(starts == 4, "R9", "frame after reset", starts, 4);
        chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);

        repeat (4) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule